// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns characters written by a host into asynchronous serial frames on one output line. A programmable divider reduces the reference clock to a tick that runs at sixteen times the bit rate. Every part of a frame is timed in these ticks: the start bit, the data bits, the optional parity bit and the stop period.

The host picks the character length, the parity mode and the stop period at run time. These settings are captured when a character moves into the shifter, so a frame is never altered while it is being sent. A holding register sits in front of the shift register. The host can therefore write the next character during the current frame, and that character follows the stop period with no idle gap.

Two status flags show whether the holding register is free and whether the whole transmit path is empty. An interrupt request follows the holding-register-empty flag when it is enabled. A break input holds the line low for as long as it is asserted.

Top module: `serial_frame_tx`

## Requirements
- R1: A non-zero `divisor_i` gives one oversampling tick every `divisor_i` clock cycles, and each bit period lasts 16 ticks. A divisor of 0 stops all ticks: a written character is never loaded and the line stays high.
- R2: `len_sel_i` sets the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits are sent least significant bit first, and bits above the selected length are not sent.
- R3: `par_sel_i` sets the parity bit that follows the data bits. 1 gives even parity, where the data bits and the parity bit together hold an even number of ones. 2 gives odd parity. 0 and 3 send no parity bit.
- R4: `stop_sel_i` sets the stop period: 0 gives 16 ticks, 1 gives 24 ticks, and 2 or 3 give 32 ticks. When frames run back to back, the time from one start-bit edge to the next equals the frame's total ticks multiplied by `divisor_i` clock cycles.
- R5: Each frame begins with a start bit that is low for 16 ticks and ends with a stop period at high level. The line is high while idle and after reset.
- R6: A write loads the holding register. A write while the holding register is full replaces the character held there. A character written during a frame starts at the very tick on which the previous stop period ends.
- R7: While `brk_i` is high, `txd_o` is low, whatever the transmitter is doing. Once `brk_i` falls, the line returns to the level the transmitter drives.
- R8: `hold_empty_o` is high when the holding register holds no character. `tx_empty_o` is high only when the holding register is empty and no frame is in progress. Both flags are high after reset.
- R9: `irq_o` is high exactly when `irq_en_i` is high and the holding register is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| divisor_i | input | 16 | Divider for the 16x tick; 0 stops the tick |
| len_sel_i | input | 2 | Character length select (5 to 8 bits) |
| par_sel_i | input | 2 | Parity select: none, even or odd |
| stop_sel_i | input | 2 | Stop period select: 1, 1.5 or 2 bits |
| brk_i | input | 1 | Forces the line low while high |
| irq_en_i | input | 1 | Enables the holding-register-empty interrupt |
| wr_i | input | 1 | One-cycle write strobe for the holding register |
| wr_data_i | input | 8 | Character to transmit |
| txd_o | output | 1 | Serial output line |
| hold_empty_o | output | 1 | Holding register is empty |
| tx_empty_o | output | 1 | Holding register and shifter are both idle |
| irq_o | output | 1 | Interrupt request |

## Verification
The tick-spacing assertion expects `divisor_i` to stay constant between two ticks, so the stimulus changes the divisor only while the transmitter is idle. The configuration selects are captured when a character is loaded. The stimulus still holds them steady for a whole pair of frames, and it uses only the encodings listed in the requirements. The stimulus waits for the start-bit edge to measure frame timing, which lets a single write strobe arrive at any phase of the divider.

// File: rtl/sft_pkg.sv
package sft_pkg;

  localparam int unsigned OVS = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [1:0] len_sel;
    logic [1:0] par_sel;
    logic [1:0] stop_sel;
  } frame_cfg_t;

  function automatic logic [3:0] data_bits(input logic [1:0] sel);
    return 4'd5 + {2'b00, sel};
  endfunction

  function automatic logic [5:0] stop_ticks(input logic [1:0] sel);
    case (sel)
      2'd0:    return 6'd16;
      2'd1:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

  function automatic logic parity_on(input logic [1:0] sel);
    return (sel == 2'd1) || (sel == 2'd2);
  endfunction

endpackage

// File: rtl/sft_baud_div.sv
module sft_baud_div #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] divisor_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic             run;
  logic             wrap;

  assign run    = |divisor_i;
  assign wrap   = cnt_q >= (divisor_i - 1'b1);
  assign tick_o = run & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run || wrap)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  // Ticks are at least divisor cycles apart while the divisor holds.
  assert_tick_spacing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && divisor_i > 1) |=> (!tick_o || !$stable(divisor_i)));

endmodule

// File: rtl/sft_hold_reg.sv
module sft_hold_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              take_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o
);

  logic [DATA_W-1:0] data_q;
  logic              full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (wr_i) data_q <= wr_data_i;
      // a write in the same cycle as a take keeps the register full
      if (wr_i)        full_q <= 1'b1;
      else if (take_i) full_q <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;

  assert_take_needs_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> full_q);

  assert_write_sets_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> full_o);

endmodule

// File: rtl/sft_shifter.sv
module sft_shifter
  import sft_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              hold_full_i,
  input  logic [DATA_W-1:0] hold_data_i,
  input  frame_cfg_t        cfg_i,
  output logic              take_o,
  output logic              line_o,
  output logic              busy_o
);

  tx_state_e         state_q;
  frame_cfg_t        cfg_q;
  logic [DATA_W-1:0] shreg_q;
  logic [5:0]        cnt_q;
  logic [3:0]        bit_q;
  logic              par_q;

  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] masked;
  logic [3:0]        nbits_new;
  logic              bit_end;
  logic              stop_end;

  assign nbits_new = data_bits(cfg_i.len_sel);

  always_comb begin
    for (int i = 0; i < DATA_W; i++) mask[i] = (i < int'(nbits_new));
  end

  assign masked   = hold_data_i & mask;
  assign bit_end  = (cnt_q == 6'(OVS - 1));
  assign stop_end = (cnt_q == stop_ticks(cfg_q.stop_sel) - 6'd1);

  assign take_o = tick_i & hold_full_i &
                  ((state_q == ST_IDLE) || ((state_q == ST_STOP) && stop_end));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      shreg_q <= '0;
      cnt_q   <= '0;
      bit_q   <= '0;
      par_q   <= 1'b0;
    end else if (take_o) begin
      state_q <= ST_START;
      cfg_q   <= cfg_i;
      shreg_q <= masked;
      cnt_q   <= '0;
      bit_q   <= '0;
      par_q   <= (cfg_i.par_sel == 2'd2) ? ~^masked : ^masked;
    end else if (tick_i) begin
      case (state_q)
        ST_START: begin
          if (bit_end) begin
            state_q <= ST_DATA;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 6'd1;
        end
        ST_DATA: begin
          if (bit_end) begin
            cnt_q   <= '0;
            shreg_q <= shreg_q >> 1;
            if (bit_q == data_bits(cfg_q.len_sel) - 4'd1) begin
              bit_q   <= '0;
              state_q <= parity_on(cfg_q.par_sel) ? ST_PARITY : ST_STOP;
            end else bit_q <= bit_q + 4'd1;
          end else cnt_q <= cnt_q + 6'd1;
        end
        ST_PARITY: begin
          if (bit_end) begin
            state_q <= ST_STOP;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 6'd1;
        end
        ST_STOP: begin
          if (stop_end) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 6'd1;
        end
        default: cnt_q <= '0;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      ST_START:  line_o = 1'b0;
      ST_DATA:   line_o = shreg_q[0];
      ST_PARITY: line_o = par_q;
      default:   line_o = 1'b1;
    endcase
  end

  assign busy_o = (state_q != ST_IDLE);

  assert_data_index_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA) |-> (bit_q < data_bits(cfg_q.len_sel)));

  assert_parity_only_when_on_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PARITY) |-> parity_on(cfg_q.par_sel));

  assert_stop_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP) |-> (cnt_q < stop_ticks(cfg_q.stop_sel)));

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sft_pkg::*;
#(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  divisor_i,
  input  logic [1:0]        len_sel_i,
  input  logic [1:0]        par_sel_i,
  input  logic [1:0]        stop_sel_i,
  input  logic              brk_i,
  input  logic              irq_en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              txd_o,
  output logic              hold_empty_o,
  output logic              tx_empty_o,
  output logic              irq_o
);

  logic              tick;
  logic              take;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              line;
  logic              busy;
  frame_cfg_t        cfg;

  assign cfg = '{len_sel: len_sel_i, par_sel: par_sel_i, stop_sel: stop_sel_i};

  sft_baud_div #(.DIV_W(DIV_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .divisor_i (divisor_i),
    .tick_o    (tick)
  );

  sft_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .take_i    (take),
    .data_o    (hold_data),
    .full_o    (hold_full)
  );

  sft_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .hold_full_i (hold_full),
    .hold_data_i (hold_data),
    .cfg_i       (cfg),
    .take_o      (take),
    .line_o      (line),
    .busy_o      (busy)
  );

  assign txd_o        = line & ~brk_i;
  assign hold_empty_o = ~hold_full;
  assign tx_empty_o   = ~hold_full & ~busy;
  assign irq_o        = irq_en_i & ~hold_full;

  assert_tx_empty_implies_hold_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> hold_empty_o);

  assert_idle_line_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_empty_o && !brk_i) |-> txd_o);

  assert_stopped_no_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (divisor_i == '0 && tx_empty_o) |=> (!busy || divisor_i != '0));

endmodule

// File: tb/serial_frame_tx_tb.sv
module serial_frame_tx_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] divisor = 16'd1;
  logic [1:0]  len_sel = 2'd3, par_sel = 2'd0, stop_sel = 2'd0;
  logic        brk = 1'b0, irq_en = 1'b0, wr = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic        txd, hold_empty, tx_empty, irq;
  longint      cyc = 0;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_frame_tx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .divisor_i(divisor), .len_sel_i(len_sel),
    .par_sel_i(par_sel), .stop_sel_i(stop_sel), .brk_i(brk), .irq_en_i(irq_en),
    .wr_i(wr), .wr_data_i(wdata), .txd_o(txd), .hold_empty_o(hold_empty),
    .tx_empty_o(tx_empty), .irq_o(irq)
  );

  // {data, len_sel, par_sel, stop_sel, divisor}
  localparam logic [17:0] VEC [0:6] = '{
    {8'hA5, 2'd3, 2'd0, 2'd0, 4'd1},
    {8'h3C, 2'd3, 2'd1, 2'd2, 4'd1},
    {8'h96, 2'd2, 2'd2, 2'd1, 4'd2},
    {8'hFF, 2'd0, 2'd1, 2'd0, 4'd3},
    {8'h0E, 2'd1, 2'd2, 2'd2, 4'd1},
    {8'h81, 2'd0, 2'd0, 2'd1, 4'd1},
    {8'h00, 2'd3, 2'd2, 2'd3, 4'd2}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int nb_of(input logic [1:0] l); return 5 + int'(l); endfunction
  function automatic int pb_of(input logic [1:0] p); return (p == 2'd1 || p == 2'd2) ? 1 : 0; endfunction
  function automatic int st_of(input logic [1:0] s);
    return (s == 2'd0) ? 16 : (s == 2'd1) ? 24 : 32;
  endfunction

  // line bits: index 0 start, then data LSB first, optional parity, first stop bit
  function automatic logic [11:0] exp_frame(input logic [7:0] d, input logic [1:0] l,
                                            input logic [1:0] p);
    logic [11:0] f = '0;
    int n = nb_of(l);
    logic ones = 1'b0;
    for (int i = 0; i < n; i++) begin
      f[1+i] = d[i];
      ones ^= d[i];
    end
    if (pb_of(p) == 1) f[1+n] = (p == 2'd2) ? ~ones : ones;
    f[1+n+pb_of(p)] = 1'b1;
    return f;
  endfunction

  task automatic write_byte(input logic [7:0] d);
    wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic capture(input int nbits, input int dv, input bit reload,
                         input logic [7:0] d2, output logic [11:0] got, output longint t0);
    got = '0;
    while (txd !== 1'b0) @(negedge clk);
    t0 = cyc;
    if (reload) begin
      wr = 1'b1; wdata = d2;
      @(negedge clk);
      wr = 1'b0;
      repeat (8*dv-1) @(negedge clk);
    end else repeat (8*dv) @(negedge clk);
    for (int k = 0; k < nbits; k++) begin
      got[k] = txd;
      if (k < nbits-1) repeat (16*dv) @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [11:0] got, exp;
    longint t0, t1;
    int lows;

    repeat (3) @(negedge clk);
    check(txd === 1'b1, "R5", "reset line", txd, 1);
    check(hold_empty === 1'b1, "R8", "reset hold_empty", hold_empty, 1);
    check(tx_empty === 1'b1, "R8", "reset tx_empty", tx_empty, 1);
    check(irq === 1'b0, "R9", "reset irq", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: two back-to-back frames per entry (R2 R3 R4 R5 R6 R1)
    for (int v = 0; v < 7; v++) begin
      logic [7:0] d;
      int nl, dv, ticks;
      d = VEC[v][17:10]; len_sel = VEC[v][9:8]; par_sel = VEC[v][7:6];
      stop_sel = VEC[v][5:4]; dv = int'(VEC[v][3:0]); divisor = 16'(dv);
      nl = 2 + nb_of(len_sel) + pb_of(par_sel);
      ticks = 16*(1 + nb_of(len_sel) + pb_of(par_sel)) + st_of(stop_sel);
      @(negedge clk);
      write_byte(d);
      capture(nl, dv, 1'b1, ~d, got, t0);
      exp = exp_frame(d, len_sel, par_sel);
      check(got == exp, "R2", "frame bits first char", got, exp);
      capture(nl, dv, 1'b0, 8'h00, got, t1);
      exp = exp_frame(~d, len_sel, par_sel);
      check(got == exp, "R3", "frame bits reloaded char", got, exp);
      check(t1 - t0 == longint'(ticks*dv), "R4", "start-to-start cycles", t1 - t0, ticks*dv);
      while (tx_empty !== 1'b1) @(negedge clk);
      check(txd === 1'b1, "R5", "idle after frames", txd, 1);
    end

    // R9 interrupt follows hold-empty when enabled
    irq_en = 1'b1;
    @(negedge clk);
    check(irq === 1'b1, "R9", "irq when empty", irq, 1);

    // R1 divisor 0 halts; R6 overwrite of full holding register
    divisor = 16'd0; len_sel = 2'd3; par_sel = 2'd0; stop_sel = 2'd0;
    write_byte(8'h5A);
    check(hold_empty === 1'b0, "R8", "hold full after write", hold_empty, 0);
    check(tx_empty === 1'b0, "R8", "tx not empty", tx_empty, 0);
    check(irq === 1'b0, "R9", "irq low when full", irq, 0);
    write_byte(8'hC3);
    lows = 0;
    for (int i = 0; i < 100; i++) begin
      if (txd !== 1'b1) lows++;
      @(negedge clk);
    end
    check(lows == 0, "R1", "line idle with divisor 0", lows, 0);
    check(hold_empty === 1'b0, "R1", "char held with divisor 0", hold_empty, 0);
    divisor = 16'd1;
    capture(10, 1, 1'b0, 8'h00, got, t0);
    exp = exp_frame(8'hC3, 2'd3, 2'd0);
    check(got == exp, "R6", "overwritten char sent", got, exp);
    while (tx_empty !== 1'b1) @(negedge clk);
    check(irq === 1'b1, "R9", "irq back after drain", irq, 1);

    // R7 break forcing
    brk = 1'b1;
    @(negedge clk);
    check(txd === 1'b0, "R7", "break idle line", txd, 0);
    write_byte(8'hFF);
    repeat (20) @(negedge clk);
    check(txd === 1'b0, "R7", "break over data ones", txd, 0);
    brk = 1'b0;
    @(negedge clk);
    check(txd === 1'b1, "R7", "line after break release (data one)", txd, 1);
    while (tx_empty !== 1'b1) @(negedge clk);
    check(txd === 1'b1, "R7", "idle after break", txd, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule